// File: doc/BRIEF.md
# Source-Synchronous Phase Alignment Sequencer

This block steers a local sampling timeline onto a clock and a data-ready strobe that arrive from a device running on its own oscillator, then records one burst of serial data. It does not generate timing itself. It tells the timing generator which period to use, through `period_sel`. It learns about the outside world only through `cmp_match`, a compare result that comes back a fixed number of cycles after the vector that produced it.

After `start`, the sequencer first lets the compare pipeline drain, running the shortened search period so the sampling point slides across the external clock. It then hunts for the external clock's falling edge and then its rising edge. It drains the pipeline again at the nominal period and waits for data-ready. It then idles for a computed centering delay so sampling sits in the middle of each bit. Finally it shifts in `WORD_LEN*NWORDS` bits. Every state that waits on an external condition has a timeout that parks the block in an error state. The outcome of a run, either a finished capture or an error, stays until reset.

The captured word leaves as a one-cycle `cap_done` strobe with `cap_word` held stable afterwards. There is no ready input and no back-pressure: the consumer must take the strobe in the cycle it appears, or read `cap_word` at any later time before the next reset.

Top module: `srcsync_align_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `phase` is 0 (idle), `period_sel` is 0, and `cap_done` and `err_halt` are 0. A `start` seen high at a clock edge in idle moves `phase` to 1 (search drain). `start` has no effect in any other phase.
- R2: `phase` stays at 1 for exactly `LATENCY` cycles, whatever `cmp_match` does, and then becomes 2. `period_sel` is 1 (shortened search period) exactly while `phase` is 1, 2 or 3, and is 0 (nominal period) otherwise.
- R3: In phase 2 (falling-edge hunt), the block stays put while `cmp_match` is 1. The first edge with `cmp_match` at 0 moves it to phase 3.
- R4: In phase 3 (rising-edge hunt), the block stays put while `cmp_match` is 0. The first edge with `cmp_match` at 1 moves it to phase 4, and `period_sel` falls to 0.
- R5: Phase 4 (nominal drain) lasts exactly `LATENCY` cycles regardless of `cmp_match`, then moves to phase 5.
- R6: In phase 5 (data-ready wait), the block stays put while `cmp_match` is 0. A 1 moves it to phase 6, or straight to phase 7 when the centering delay is zero.
- R7: Phase 6 (centering) lasts exactly `WORD_LEN*NWORDS - (LATENCY+2)` cycles, then moves to phase 7. A configuration where this count is negative is rejected at elaboration.
- R8: Phase 7 (capture) samples `data_in` on `WORD_LEN*NWORDS` consecutive edges. The first sample ends up in the MSB of `cap_word`. On the cycle after the last sample, `phase` is 8 and `cap_done` is high for that single cycle.
- R9: Phase 8 (halt) persists until reset, and `cap_word` holds the captured value.
- R10: If phase 2, 3 or 5 sees no exit condition within `TMO_LIMIT` cycles, `phase` becomes 9 (error halt) and `err_halt` goes to 1. Both persist until reset, and `period_sel` is 0 there.
- R11: Driving `rst_n` low in any phase returns the block to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one tick per issued vector |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the sequence from idle |
| cmp_match | input | 1 | Compare result, delayed by the pipeline latency |
| data_in | input | 1 | Serial data bit sampled during capture |
| period_sel | output | 1 | 1 selects the shortened search period, 0 selects the nominal period |
| phase | output | 4 | Current sequence phase code (0 to 9) |
| cap_done | output | 1 | One-cycle strobe when the capture completes |
| cap_word | output | WORD_LEN*NWORDS | Captured bits, first sample in the MSB |
| err_halt | output | 1 | High once a search has timed out |

## Verification
The states that are hardest to reach are the timeout exits. The bench has to hold `cmp_match` steady through a full drain window and then through `TMO_LIMIT` more cycles, and the drain it passes through must itself be shown to ignore `cmp_match`. Inside each drain window, the stimulus therefore drives the very level that would cause an exit in the next hunt state, and switches it only on the last drain cycle. A stuck-high clock compare then reaches the falling-edge timeout, and a data-ready that never rises reaches the second timeout. The bench is built with a reduced `TMO_LIMIT` so these exits stay short.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  typedef enum logic [3:0] {
    PH_IDLE    = 4'd0,
    PH_FLUSH_S = 4'd1,
    PH_FALL    = 4'd2,
    PH_RISE    = 4'd3,
    PH_FLUSH_N = 4'd4,
    PH_DRDY    = 4'd5,
    PH_CENTER  = 4'd6,
    PH_CAPTURE = 4'd7,
    PH_HALT    = 4'd8,
    PH_ERROR   = 4'd9
  } ssa_phase_e;

endpackage

// File: rtl/ssa_cnt.sv
module ssa_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    value <= '0;
    else if (load)                 value <= load_val;
    else if (dec && value != '0)   value <= value - 1'b1;
  end

  assign zero = (value == '0);

endmodule

// File: rtl/ssa_capture.sv
module ssa_capture #(
  parameter int BITS = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            finish,
  input  logic            data_in,
  output logic [BITS-1:0] word,
  output logic            done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (shift_en) word <= {word[BITS-2:0], data_in};
    end
  end

  // R8: completion strobe lasts exactly one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: captured word is frozen once capture has finished
  a_r9_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !shift_en) |=> $stable(word));

endmodule

// File: rtl/ssa_ctrl.sv
module ssa_ctrl
  import ssa_pkg::*;
#(
  parameter int LATENCY    = 80,
  parameter int BITS       = 128,
  parameter int CENTER_CYC = 46,
  parameter int TMO_LIMIT  = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cmp_match,
  output ssa_phase_e state,
  output logic       shift_en,
  output logic       finish
);

  localparam int  MAXC       = (LATENCY > BITS) ? LATENCY : BITS;
  localparam int  CW         = $clog2(MAXC + 1);
  localparam int  TW         = $clog2(TMO_LIMIT + 1);
  localparam bit  HAS_CENTER = (CENTER_CYC > 0);
  localparam int  CEN_LOAD   = HAS_CENTER ? CENTER_CYC - 1 : 0;

  ssa_phase_e    nxt;
  logic          ld_main, ld_tmo;
  logic [CW-1:0] main_val;
  logic          main_zero, tmo_zero;

  always_comb begin
    nxt      = state;
    ld_main  = 1'b0;
    main_val = '0;
    ld_tmo   = 1'b0;
    case (state)
      PH_IDLE: if (start) begin
        nxt = PH_FLUSH_S; ld_main = 1'b1; main_val = CW'(LATENCY - 1);
      end
      PH_FLUSH_S: if (main_zero) begin
        nxt = PH_FALL; ld_tmo = 1'b1;
      end
      PH_FALL: begin
        if (!cmp_match) begin
          nxt = PH_RISE; ld_tmo = 1'b1;
        end else if (tmo_zero) nxt = PH_ERROR;
      end
      PH_RISE: begin
        if (cmp_match) begin
          nxt = PH_FLUSH_N; ld_main = 1'b1; main_val = CW'(LATENCY - 1);
        end else if (tmo_zero) nxt = PH_ERROR;
      end
      PH_FLUSH_N: if (main_zero) begin
        nxt = PH_DRDY; ld_tmo = 1'b1;
      end
      PH_DRDY: begin
        if (cmp_match) begin
          ld_main = 1'b1;
          if (HAS_CENTER) begin
            nxt = PH_CENTER; main_val = CW'(CEN_LOAD);
          end else begin
            nxt = PH_CAPTURE; main_val = CW'(BITS - 1);
          end
        end else if (tmo_zero) nxt = PH_ERROR;
      end
      PH_CENTER: if (main_zero) begin
        nxt = PH_CAPTURE; ld_main = 1'b1; main_val = CW'(BITS - 1);
      end
      PH_CAPTURE: if (main_zero) nxt = PH_HALT;
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_IDLE;
    else        state <= nxt;
  end

  ssa_cnt #(.W(CW)) u_main_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld_main), .load_val(main_val),
    .dec(!ld_main), .zero(main_zero)
  );

  ssa_cnt #(.W(TW)) u_tmo_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld_tmo), .load_val(TW'(TMO_LIMIT - 1)),
    .dec(!ld_tmo), .zero(tmo_zero)
  );

  assign shift_en = (state == PH_CAPTURE);
  assign finish   = (state == PH_CAPTURE) && main_zero;

  // R2: drain window is not cut short by compare results
  a_r2_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_FLUSH_S && !main_zero) |=> state == PH_FLUSH_S);

  // R3: falling edge seen moves to the rising-edge hunt
  a_r3_fall_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_FALL && !cmp_match) |=> state == PH_RISE);

  // R4: rising edge seen ends alignment
  a_r4_rise_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_RISE && cmp_match) |=> state == PH_FLUSH_N);

  // R6: data-ready seen leaves the wait
  a_r6_drdy_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_DRDY && cmp_match) |=> (state == PH_CENTER || state == PH_CAPTURE));

  // R9: halt is sticky
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    state == PH_HALT |=> state == PH_HALT);

  // R10: error halt is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    state == PH_ERROR |=> state == PH_ERROR);

endmodule

// File: rtl/srcsync_align_seq.sv
module srcsync_align_seq
  import ssa_pkg::*;
#(
  parameter int LATENCY   = 80,
  parameter int WORD_LEN  = 16,
  parameter int NWORDS    = 8,
  parameter int TMO_LIMIT = 4096,
  localparam int BITS       = WORD_LEN * NWORDS,
  localparam int CENTER_CYC = BITS - (LATENCY + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cmp_match,
  input  logic            data_in,
  output logic            period_sel,
  output logic [3:0]      phase,
  output logic            cap_done,
  output logic [BITS-1:0] cap_word,
  output logic            err_halt
);

  // R7: a negative centering delay is an illegal configuration
  if (CENTER_CYC < 0) begin : g_bad_cfg
    $error("centering delay negative: WORD_LEN*NWORDS must be >= LATENCY+2");
  end

  ssa_phase_e state;
  logic       shift_en, finish;

  ssa_ctrl #(
    .LATENCY(LATENCY), .BITS(BITS), .CENTER_CYC(CENTER_CYC), .TMO_LIMIT(TMO_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_match(cmp_match),
    .state(state), .shift_en(shift_en), .finish(finish)
  );

  ssa_capture #(.BITS(BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .finish(finish),
    .data_in(data_in), .word(cap_word), .done(cap_done)
  );

  assign phase      = state;
  assign period_sel = (state == PH_FLUSH_S) || (state == PH_FALL) || (state == PH_RISE);
  assign err_halt   = (state == PH_ERROR);

  // R8: the completion strobe coincides with entry into halt
  a_r8_done_at_halt: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> (phase == 4'd8 && $past(phase) == 4'd7));

endmodule

// File: tb/srcsync_align_seq_test.sv
module srcsync_align_seq_test;

  localparam int LAT  = 80;
  localparam int WL   = 16;
  localparam int NW   = 8;
  localparam int TMO  = 300;
  localparam int BITS = WL * NW;
  localparam int CEN  = BITS - (LAT + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_match = 1'b0;
  logic data_in = 1'b0;
  logic period_sel, cap_done, err_halt;
  logic [3:0] phase;
  logic [BITS-1:0] cap_word;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  srcsync_align_seq #(
    .LATENCY(LAT), .WORD_LEN(WL), .NWORDS(NW), .TMO_LIMIT(TMO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_match(cmp_match),
    .data_in(data_in), .period_sel(period_sel), .phase(phase),
    .cap_done(cap_done), .cap_word(cap_word), .err_halt(err_halt)
  );

  task automatic chk(input bit ok, input string req, input logic [BITS-1:0] act,
                     input logic [BITS-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_phase(input string req, input logic [3:0] exp);
    chk(phase == exp, req, BITS'(phase), BITS'(exp));
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; cmp_match = 1'b0; data_in = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  // start, drain with cmp_match low (ignored), land in phase 2 with cmp_match high
  task automatic run_to_fall();
    start = 1'b1;
    tick(1);
    start = 1'b0;
    chk_phase("R1 start enters drain", 4'd1);
    chk(period_sel == 1'b1, "R2 search period in drain", BITS'(period_sel), 1);
    cmp_match = 1'b0;
    tick(LAT - 1);
    chk_phase("R2 drain ignores cmp_match", 4'd1);
    cmp_match = 1'b1;
    tick(1);
    chk_phase("R2 drain length", 4'd2);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk_phase("R1 reset phase", 4'd0);
    chk(period_sel == 1'b0, "R1 reset period_sel", BITS'(period_sel), 0);
    chk(cap_done == 1'b0 && err_halt == 1'b0, "R1 reset flags",
        BITS'({cap_done, err_halt}), 0);
  endtask

  task automatic t_full_sequence();
    logic [BITS-1:0] pat;
    pat = {4{32'hA5C3_0F96}} ^ {BITS{1'b0}} ^ {{(BITS-8){1'b0}}, 8'h5A};
    do_reset();
    run_to_fall();
    tick(5);
    chk_phase("R3 holds while clock compare matches", 4'd2);
    cmp_match = 1'b0;
    tick(1);
    chk_phase("R3 falling edge found", 4'd3);
    chk(period_sel == 1'b1, "R2 search period in rise hunt", BITS'(period_sel), 1);
    tick(4);
    chk_phase("R4 holds while no match", 4'd3);
    cmp_match = 1'b1;
    tick(1);
    chk_phase("R4 rising edge found", 4'd4);
    chk(period_sel == 1'b0, "R4 nominal period after alignment", BITS'(period_sel), 0);
    start = 1'b1;
    tick(LAT - 1);
    chk_phase("R5 nominal drain ignores cmp_match and R1 start", 4'd4);
    cmp_match = 1'b0;
    start = 1'b0;
    tick(1);
    chk_phase("R5 drain length", 4'd5);
    tick(3);
    chk_phase("R6 waits for data-ready", 4'd5);
    cmp_match = 1'b1;
    tick(1);
    chk_phase("R6 data-ready found", 4'd6);
    cmp_match = 1'b0;
    tick(CEN - 1);
    chk_phase("R7 centering still running", 4'd6);
    tick(1);
    chk_phase("R7 centering length", 4'd7);
    for (int i = 0; i < BITS; i++) begin
      data_in = pat[BITS-1-i];
      if (i == BITS - 1) chk(cap_done == 1'b0, "R8 no early done", BITS'(cap_done), 0);
      tick(1);
    end
    chk_phase("R8 halt after capture", 4'd8);
    chk(cap_done == 1'b1, "R8 done strobe", BITS'(cap_done), 1);
    chk(cap_word == pat, "R8 captured word", cap_word, pat);
    data_in = 1'b1;
    start = 1'b1;
    tick(1);
    chk(cap_done == 1'b0, "R8 done lasts one cycle", BITS'(cap_done), 0);
    tick(3);
    start = 1'b0;
    chk_phase("R9 halt sticky", 4'd8);
    chk(cap_word == pat, "R9 word held", cap_word, pat);
  endtask

  task automatic t_timeout_fall();
    do_reset();
    run_to_fall();
    tick(TMO - 1);
    chk_phase("R10 still hunting before limit", 4'd2);
    tick(1);
    chk_phase("R10 fall hunt timeout", 4'd9);
    chk(err_halt == 1'b1, "R10 err_halt set", BITS'(err_halt), 1);
    chk(period_sel == 1'b0, "R10 nominal period in error", BITS'(period_sel), 0);
    start = 1'b1;
    cmp_match = 1'b0;
    tick(3);
    start = 1'b0;
    chk_phase("R10 error sticky", 4'd9);
  endtask

  task automatic t_timeout_drdy();
    do_reset();
    run_to_fall();
    cmp_match = 1'b0;
    tick(1);
    cmp_match = 1'b1;
    tick(1);
    chk_phase("R4 reached nominal drain", 4'd4);
    cmp_match = 1'b0;
    tick(LAT);
    chk_phase("R5 reached data-ready wait", 4'd5);
    tick(TMO - 1);
    chk_phase("R10 data-ready still waiting", 4'd5);
    tick(1);
    chk_phase("R10 data-ready timeout", 4'd9);
  endtask

  task automatic t_mid_reset();
    do_reset();
    start = 1'b1;
    tick(1);
    start = 1'b0;
    tick(10);
    rst_n = 1'b0;
    #1;
    chk_phase("R11 async return to idle", 4'd0);
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk_phase("R11 idle after release", 4'd0);
    run_to_fall();
  endtask

  initial begin
    t_reset_state();
    t_full_sequence();
    t_timeout_fall();
    t_timeout_drdy();
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule